// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two doorbell interrupts of a two-port memory. Each port owns one mailbox word near the top of the address space: the left port's mailbox is the second-highest address (0x7FE with 11 address bits) and the right port's mailbox is the highest address (0x7FF). A port posts a message by writing into the other side's mailbox. That write raises the receiving side's interrupt flag, and the flag stays raised until the receiving side reads its own mailbox.

The block only watches the port controls. The mailbox words stay ordinary memory locations held in the storage array next to it, so a mailbox write still stores data and a mailbox read still returns it. A global function enable switches the doorbells off. With it low, both mailbox addresses are plain storage and neither flag is ever raised.

Each flag is a registered, always-driven, active-low output that reacts on the clock edge after the qualifying access.

Top module: `mbox_irq_top`

## Requirements
- R1: While reset is active and right after it, both `a_irq_n` and `b_irq_n` are 1 (no interrupt pending).
- R2: A right-port write (`b_en`=1, `b_wr`=1) to the left mailbox 0x7FE with `irq_en`=1 drives `a_irq_n` to 0 on the next clock edge.
- R3: A left-port write (`a_en`=1, `a_wr`=1) to the right mailbox 0x7FF with `irq_en`=1 drives `b_irq_n` to 0 on the next clock edge.
- R4: A left-port read access (`a_en`=1, `a_oe`=1) to 0x7FE returns `a_irq_n` to 1 on the next edge, whatever the value of `a_wr`.
- R5: A right-port read access (`b_en`=1, `b_oe`=1) to 0x7FF returns `b_irq_n` to 1 on the next edge, whatever the value of `b_wr`.
- R6: In any cycle with no set and no clear event for a flag, that flag keeps its value. Accesses to other addresses have no effect, and neither does a mailbox access with `*_en`=0 or with `*_oe`=0 on the receiving side.
- R7: A port writing its own mailbox with its output enable at 0 leaves that port's flag unchanged.
- R8: If a set event and a clear event for the same flag fall in the same cycle, the flag ends up set (0).
- R9: With `irq_en`=0, both flags return to 1 on the next edge, and mailbox writes raise no flag.
- R10: The two flags are independent: an event for one flag never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Enables the mailbox interrupt function |
| a_en | input | 1 | Left port selected |
| a_oe | input | 1 | Left port output (read) enable |
| a_wr | input | 1 | Left port write strobe |
| a_addr | input | ADDR_W (11) | Left port address |
| b_en | input | 1 | Right port selected |
| b_oe | input | 1 | Right port output (read) enable |
| b_wr | input | 1 | Right port write strobe |
| b_addr | input | ADDR_W (11) | Right port address |
| a_irq_n | output | 1 | Left port interrupt, active low |
| b_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with the default `ADDR_W`=11, which puts the mailboxes at 0x7FE and 0x7FF. At that width the neighbouring address 0x7FD and the bottom address 0x000 are exact near-miss probes for the address decode. A directed phase covers set, clear, same-cycle races and the function enable. A random phase then draws addresses only from those four values, so mailbox hits, own-mailbox writes and simultaneous post/read pairs occur often. After every edge both flags are compared against a behavioural model.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    typedef struct packed {
        logic en;
        logic oe;
        logic wr;
    } port_ctl_t;

    typedef struct packed {
        logic pend;
    } flag_state_t;

    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_irq_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 11,
    parameter logic [ADDR_W-1:0]    OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0]    PEER_BOX = '0
) (
    input  port_ctl_t               ctl,
    input  logic [ADDR_W-1:0]       addr,
    output logic                    own_ack,
    output logic                    peer_post
);

    always_comb begin
        own_ack   = ctl.en && ctl.oe && (addr == OWN_BOX);
        peer_post = ctl.en && ctl.wr && (addr == PEER_BOX);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic func_en,
    input  logic post,
    input  logic ack,
    output logic irq_n
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!func_en) begin
            st_d.pend = 1'b0;
        end else if (post) begin
            st_d.pend = 1'b1;
        end else if (ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.pend;

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              a_en,
    input  logic              a_oe,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_oe,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_A    = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] BOX_B    = TOP_ADDR;

    port_ctl_t         ctl   [NUM_PORTS];
    logic [ADDR_W-1:0] addr  [NUM_PORTS];
    logic              ack   [NUM_PORTS];
    logic              post  [NUM_PORTS];
    logic              irq_v [NUM_PORTS];

    always_comb begin
        ctl[0]  = '{en: a_en, oe: a_oe, wr: a_wr};
        ctl[1]  = '{en: b_en, oe: b_oe, wr: b_wr};
        addr[0] = a_addr;
        addr[1] = b_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
        localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_B : BOX_A;

        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .ctl       (ctl[p]),
            .addr      (addr[p]),
            .own_ack   (ack[p]),
            .peer_post (post[p])
        );

        mbox_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .func_en (irq_en),
            .post    (post[NUM_PORTS-1-p]),
            .ack     (ack[p]),
            .irq_n   (irq_v[p])
        );
    end

    assign a_irq_n = irq_v[0];
    assign b_irq_n = irq_v[1];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              a_en,
    input logic              a_oe,
    input logic              a_wr,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_en,
    input logic              b_oe,
    input logic              b_wr,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_irq_n,
    input logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] MB_LEFT  = {ADDR_W{1'b1}} - 1'b1;
    localparam logic [ADDR_W-1:0] MB_RIGHT = {ADDR_W{1'b1}};

    logic set_l, set_r, clr_l, clr_r;
    assign set_l = irq_en && b_en && b_wr && (b_addr == MB_LEFT);
    assign set_r = irq_en && a_en && a_wr && (a_addr == MB_RIGHT);
    assign clr_l = a_en && a_oe && (a_addr == MB_LEFT);
    assign clr_r = b_en && b_oe && (b_addr == MB_RIGHT);

    assert_rst_R1: assert property (@(posedge clk)
        !rst_n |-> (a_irq_n && b_irq_n));

    assert_set_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !a_irq_n);

    assert_set_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !b_irq_n);

    assert_clr_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && clr_l && !set_l) |=> a_irq_n);

    assert_clr_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && clr_r && !set_r) |=> b_irq_n);

    assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !set_l && !clr_l) |=> $stable(a_irq_n));

    assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !set_r && !clr_r) |=> $stable(b_irq_n));

    assert_race_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_l && clr_l) |=> !a_irq_n);

    assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> (a_irq_n && b_irq_n));

endmodule

bind mbox_irq_top mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (irq_en),
    .a_en    (a_en),
    .a_oe    (a_oe),
    .a_wr    (a_wr),
    .a_addr  (a_addr),
    .b_en    (b_en),
    .b_oe    (b_oe),
    .b_wr    (b_wr),
    .b_addr  (b_addr),
    .a_irq_n (a_irq_n),
    .b_irq_n (b_irq_n)
);

// File: tb/tb_mbox_irq_top.sv
`timescale 1ns/1ps
module tb_mbox_irq_top;

    localparam int unsigned AW = 11;
    localparam logic [AW-1:0] LBOX = 11'h7FE;
    localparam logic [AW-1:0] RBOX = 11'h7FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_en, a_en, a_oe, a_wr, b_en, b_oe, b_wr;
    logic [AW-1:0] a_addr, b_addr;
    logic a_irq_n, b_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit pend_l = 1'b0;
    bit pend_r = 1'b0;

    always #4 clk = ~clk;

    mbox_irq_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .a_en(a_en), .a_oe(a_oe), .a_wr(a_wr), .a_addr(a_addr),
        .b_en(b_en), .b_oe(b_oe), .b_wr(b_wr), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    task automatic idle();
        a_en = 0; a_oe = 0; a_wr = 0; a_addr = '0;
        b_en = 0; b_oe = 0; b_wr = 0; b_addr = '0;
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (a_irq_n !== ~pend_l || b_irq_n !== ~pend_r) begin
            n_bad++;
            $display("FAIL %s: a_irq_n=%b exp %b, b_irq_n=%b exp %b",
                     tag, a_irq_n, ~pend_l, b_irq_n, ~pend_r);
        end
    endtask

    // one clock: model follows the requirements, compare half a period later
    task automatic cyc(input string tag);
        bit post_l, post_r, read_l, read_r;
        @(posedge clk);
        post_l = b_en && b_wr && b_addr == LBOX;
        post_r = a_en && a_wr && a_addr == RBOX;
        read_l = a_en && a_oe && a_addr == LBOX;
        read_r = b_en && b_oe && b_addr == RBOX;
        if (!irq_en) begin
            pend_l = 0; pend_r = 0;
        end else begin
            if (post_l) pend_l = 1; else if (read_l) pend_l = 0;
            if (post_r) pend_r = 1; else if (read_r) pend_r = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        irq_en = 1;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        cyc("R1");

        // R2: right port posts to left mailbox
        b_en = 1; b_wr = 1; b_addr = LBOX; cyc("R2");
        idle(); cyc("R6");
        a_en = 1; a_oe = 1; a_addr = 11'h7FD; cyc("R6");
        idle(); a_en = 1; a_addr = LBOX; cyc("R6");
        idle(); a_oe = 1; a_addr = LBOX; cyc("R6");
        // R4: clear with write strobe high
        idle(); a_en = 1; a_oe = 1; a_wr = 1; a_addr = LBOX; cyc("R4");

        // R3 and R10: left posts right, left flag untouched
        idle(); a_en = 1; a_wr = 1; a_addr = RBOX; cyc("R3");
        idle(); cyc("R10");
        // R7: own-mailbox writes without output enable
        a_en = 1; a_wr = 1; a_addr = LBOX; cyc("R7");
        idle(); b_en = 1; b_wr = 1; b_addr = RBOX; cyc("R7");
        // R5: right reads its mailbox
        idle(); b_en = 1; b_oe = 1; b_addr = RBOX; cyc("R5");

        // R8: same-cycle set and clear
        idle(); b_en = 1; b_wr = 1; b_addr = LBOX;
        a_en = 1; a_oe = 1; a_addr = LBOX; cyc("R8");
        idle(); a_en = 1; a_wr = 1; a_addr = RBOX;
        b_en = 1; b_oe = 1; b_addr = RBOX; cyc("R8");
        idle(); cyc("R10");

        // R9: function disabled
        irq_en = 0; cyc("R9");
        b_en = 1; b_wr = 1; b_addr = LBOX;
        a_en = 1; a_wr = 1; a_addr = RBOX; cyc("R9");
        idle(); irq_en = 1; cyc("R9");
        b_en = 1; b_wr = 1; b_addr = LBOX; cyc("R2");
        idle(); a_addr = 11'h000; a_en = 1; a_oe = 1; cyc("R6");

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] pick [4];
            pick[0] = LBOX; pick[1] = RBOX; pick[2] = 11'h7FD; pick[3] = 11'h000;
            a_en = $urandom_range(0, 1); a_oe = $urandom_range(0, 1);
            a_wr = $urandom_range(0, 1); a_addr = pick[$urandom_range(0, 3)];
            b_en = $urandom_range(0, 1); b_oe = $urandom_range(0, 1);
            b_wr = $urandom_range(0, 1); b_addr = pick[$urandom_range(0, 3)];
            irq_en = ($urandom_range(0, 15) != 0);
            cyc("R6");
        end

        idle(); irq_en = 1; cyc("R6");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule